// File: doc/BRIEF.md
# Isochronous receive packet retirement checker

This block watches the packets arriving for one isochronous receive endpoint during a (micro)frame and decides when the transfer descriptor currently in use is finished. It also decides which error flags go with that finish. When a descriptor is loaded, a packets-per-frame down-counter is armed. Its start value is the descriptor's own multiplier override if that is nonzero, and the queue-head multiplier otherwise. At the same time a byte accumulator is cleared and the descriptor's byte budget is captured.

Each accepted packet decrements the counter and adds its byte count to the accumulator. The descriptor is retired when the burst is complete, when a packet ends it early, or when a packet breaks the length, budget or CRC rules. It is also retired when the frame ends with only part of the burst delivered. The retire pulse and the flags are registered. The flags remain readable until the next descriptor load, so the surrounding logic can write back descriptor status at leisure.

Top module: `isorx_retire`

## Requirements
- R1: On `desc_load`, the effective multiplier is `dtd_mult` when that field is nonzero, and `qh_mult` otherwise.
- R2: After the effective-multiplier number of MDATA packets with no error, the descriptor retires with both flags low.
- R3: A packet whose PID is not MDATA retires the descriptor with no flag. The PID code is 2 bits: 0 = DATA0, 1 = DATA1, 2 = DATA2, 3 = MDATA.
- R4: A packet with `pkt_bytes` greater than `max_len` sets `buf_err` and retires the descriptor. A packet exactly `max_len` long is accepted normally.
- R5: A packet that makes the accumulated byte count exceed the budget captured at load sets `buf_err` and retires the descriptor. Reaching the budget exactly is accepted.
- R6: A packet with `pkt_crc_bad` high sets `txn_err` and retires the descriptor.
- R7: On `frame_end`, if at least one packet has been accepted but fewer than the effective multiplier, `txn_err` is set and the descriptor retires. A packet in the same cycle is counted first.
- R8: A `frame_end` with no accepted packets gives no retire and no flag, and the descriptor stays armed.
- R9: `retire` is high for one cycle, in the cycle after the deciding event. The flags are valid in that cycle, hold until the next `desc_load`, and are cleared by it.
- R10: While no descriptor is armed (after a retire, or before the first load), packets and `frame_end` have no effect.
- R11: A load whose effective multiplier is zero retires in the next cycle with both flags low.
- R12: During and after reset, `retire`, `buf_err` and `txn_err` are low and no descriptor is armed.
- R13: A `desc_load` in the same cycle as a packet takes precedence, and that packet is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_load | input | 1 | Arm a new descriptor this cycle |
| dtd_mult | input | MULT_W | Per-descriptor multiplier override (0 = use queue head) |
| qh_mult | input | MULT_W | Queue-head packets-per-frame multiplier |
| dtd_budget | input | BUD_W | Total byte allocation of the descriptor |
| max_len | input | LEN_W | Maximum packet length |
| pkt_valid | input | 1 | A received data packet completes this cycle |
| pkt_pid | input | 2 | Data PID code of the packet |
| pkt_bytes | input | LEN_W | Byte count of the packet |
| pkt_crc_bad | input | 1 | Packet failed its CRC |
| frame_end | input | 1 | End of the current (micro)frame |
| retire | output | 1 | One-cycle descriptor retire pulse |
| buf_err | output | 1 | Buffer error (length or budget overrun) |
| txn_err | output | 1 | Transaction error (CRC or unfulfilled burst) |

## Verification
The bench builds the block with MULT_W = 2, LEN_W = 8 and BUD_W = 10. With these values a three-packet burst, a maximum length of 200 bytes and a 300-byte budget are all small enough for short directed sequences to hit the exact-limit and one-past-limit cases. The same values let the override and the queue-head multiplier differ, and let a zero multiplier be driven. A behavioural model of the same rules is compared with the outputs on every clock, alongside directed checks at each deciding cycle.

// File: rtl/isorx_pkg.sv
package isorx_pkg;
   typedef enum logic [1:0] {
      PID_D0 = 2'd0,
      PID_D1 = 2'd1,
      PID_D2 = 2'd2,
      PID_MD = 2'd3
   } isorx_pid_e;
endpackage

// File: rtl/isorx_pkt_ctr.sv
module isorx_pkt_ctr #(
   parameter int MULT_W = 2,
   parameter bit OVR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [MULT_W-1:0] ovr,
   input  logic [MULT_W-1:0] qh_mult,
   input  logic              take,
   output logic              eff_zero,
   output logic              last_pkt,
   output logic              got_any
);
   logic [MULT_W-1:0] eff;
   logic [MULT_W-1:0] left_q;
   logic [MULT_W-1:0] mult_q;

   generate
      if (OVR_EN) begin : g_ovr
         assign eff = (ovr != '0) ? ovr : qh_mult;
      end else begin : g_qh_only
         logic unused_ovr;
         assign unused_ovr = ^ovr;
         assign eff = qh_mult;
      end
   endgenerate

   assign eff_zero = (eff == '0);
   assign last_pkt = (left_q == MULT_W'(1));
   assign got_any  = (left_q != mult_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         mult_q <= '0;
      end else if (load) begin
         left_q <= eff;
         mult_q <= eff;
      end else if (take) begin
         left_q <= left_q - MULT_W'(1);
      end
   end

   // R1: remaining count never exceeds the loaded multiplier
   p_left_le_mult_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= mult_q);
   // R2: a packet is only taken while the counter is nonzero
   p_no_wrap_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      take |-> left_q != '0);
endmodule

// File: rtl/isorx_byte_acc.sv
module isorx_byte_acc #(
   parameter int LEN_W = 11,
   parameter int BUD_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [BUD_W-1:0] budget,
   input  logic             take,
   input  logic [LEN_W-1:0] bytes,
   input  logic [LEN_W-1:0] max_len,
   input  logic             active,
   output logic             too_long,
   output logic             over_budget
);
   localparam int SUM_W = ((BUD_W > LEN_W) ? BUD_W : LEN_W) + 1;

   logic [SUM_W-1:0] acc_q;
   logic [SUM_W-1:0] bud_q;
   logic [SUM_W-1:0] sum;

   assign sum         = acc_q + SUM_W'(bytes);
   assign too_long    = (bytes > max_len);
   assign over_budget = (sum > bud_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         bud_q <= '0;
      end else if (load) begin
         acc_q <= '0;
         bud_q <= SUM_W'(budget);
      end else if (take) begin
         acc_q <= sum;
      end
   end

   // R5: an armed descriptor never holds more bytes than its budget
   p_acc_budget_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      active |-> acc_q <= bud_q);
endmodule

// File: rtl/isorx_retire.sv
module isorx_retire #(
   parameter int MULT_W = 2,
   parameter int LEN_W  = 11,
   parameter int BUD_W  = 14,
   parameter bit OVR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              desc_load,
   input  logic [MULT_W-1:0] dtd_mult,
   input  logic [MULT_W-1:0] qh_mult,
   input  logic [BUD_W-1:0]  dtd_budget,
   input  logic [LEN_W-1:0]  max_len,
   input  logic              pkt_valid,
   input  logic [1:0]        pkt_pid,
   input  logic [LEN_W-1:0]  pkt_bytes,
   input  logic              pkt_crc_bad,
   input  logic              frame_end,
   output logic              retire,
   output logic              buf_err,
   output logic              txn_err
);
   import isorx_pkg::*;

   if (MULT_W < 1 || MULT_W > 8) begin : g_bad_mult
      $error("isorx_retire: MULT_W must be 1..8");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("isorx_retire: LEN_W must be at least 1");
   end
   if (BUD_W < LEN_W) begin : g_bad_bud
      $error("isorx_retire: BUD_W must be at least LEN_W");
   end

   logic       active_q;
   logic       take;
   logic       eff_zero, last_pkt, got_any;
   logic       too_long, over_budget;
   logic       pkt_done, fe_fail, size_err;
   isorx_pid_e pid;

   assign pid      = isorx_pid_e'(pkt_pid);
   assign take     = pkt_valid & active_q & ~desc_load;
   assign size_err = too_long | over_budget;
   assign pkt_done = take & (size_err | pkt_crc_bad | (pid != PID_MD) | last_pkt);
   assign fe_fail  = frame_end & active_q & ~desc_load & ~pkt_done & (got_any | take);

   isorx_pkt_ctr #(.MULT_W(MULT_W), .OVR_EN(OVR_EN)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (desc_load),
      .ovr      (dtd_mult),
      .qh_mult  (qh_mult),
      .take     (take),
      .eff_zero (eff_zero),
      .last_pkt (last_pkt),
      .got_any  (got_any)
   );

   isorx_byte_acc #(.LEN_W(LEN_W), .BUD_W(BUD_W)) u_acc (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (desc_load),
      .budget      (dtd_budget),
      .take        (take),
      .bytes       (pkt_bytes),
      .max_len     (max_len),
      .active      (active_q),
      .too_long    (too_long),
      .over_budget (over_budget)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         retire   <= 1'b0;
         buf_err  <= 1'b0;
         txn_err  <= 1'b0;
      end else if (desc_load) begin
         active_q <= ~eff_zero;
         retire   <= eff_zero;
         buf_err  <= 1'b0;
         txn_err  <= 1'b0;
      end else begin
         retire <= pkt_done | fe_fail;
         if (pkt_done | fe_fail) active_q <= 1'b0;
         if (take & size_err) buf_err <= 1'b1;
         if ((take & pkt_crc_bad) | fe_fail) txn_err <= 1'b1;
      end
   end

   // R9: no back-to-back retire without a new load
   p_pulse_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (retire && !desc_load) |=> !retire);
   // R9: a flag only rises together with a retire
   p_flag_rise_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(buf_err) || $rose(txn_err)) |-> retire);
   // R9: flags only clear after a load
   p_flag_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(buf_err) || $fell(txn_err)) |-> $past(desc_load));
   // R8: an empty frame end does not retire
   p_empty_frame_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && active_q && !got_any && !pkt_valid && !desc_load) |=> !retire);
   // R10: nothing retires while idle unless a load arrives
   p_idle_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !desc_load) |=> !retire);
endmodule

// File: tb/isorx_retire_bench.sv
module isorx_retire_bench;
   localparam int MW = 2;
   localparam int LW = 8;
   localparam int BW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          desc_load = 1'b0;
   logic [MW-1:0] dtd_mult = '0;
   logic [MW-1:0] qh_mult = '0;
   logic [BW-1:0] dtd_budget = '0;
   logic [LW-1:0] max_len = LW'(200);
   logic          pkt_valid = 1'b0;
   logic [1:0]    pkt_pid = 2'd0;
   logic [LW-1:0] pkt_bytes = '0;
   logic          pkt_crc_bad = 1'b0;
   logic          frame_end = 1'b0;
   logic          retire, buf_err, txn_err;

   int    total = 0;
   int    bad = 0;
   bit    finished = 1'b0;
   string cur_req = "R12";

   // behavioural reference state
   bit m_active, m_ret, m_buf, m_txn;
   int m_left, m_mult, m_acc, m_bud;

   always #5 clk = ~clk;

   isorx_retire #(.MULT_W(MW), .LEN_W(LW), .BUD_W(BW)) u_isorx_retire (
      .clk(clk), .rst_n(rst_n), .desc_load(desc_load), .dtd_mult(dtd_mult),
      .qh_mult(qh_mult), .dtd_budget(dtd_budget), .max_len(max_len),
      .pkt_valid(pkt_valid), .pkt_pid(pkt_pid), .pkt_bytes(pkt_bytes),
      .pkt_crc_bad(pkt_crc_bad), .frame_end(frame_end),
      .retire(retire), .buf_err(buf_err), .txn_err(txn_err)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_active = 0; m_ret = 0; m_buf = 0; m_txn = 0;
         m_left = 0; m_mult = 0; m_acc = 0; m_bud = 0;
      end else begin
         m_ret = 0;
         if (desc_load) begin
            m_mult = (dtd_mult != 0) ? int'(dtd_mult) : int'(qh_mult);
            m_left = m_mult;
            m_acc = 0;
            m_bud = int'(dtd_budget);
            m_buf = 0; m_txn = 0;
            m_active = (m_mult != 0);
            m_ret = (m_mult == 0);
         end else if (m_active) begin
            bit done;
            bit seen;
            done = 0;
            seen = (m_left != m_mult);
            if (pkt_valid) begin
               seen = 1;
               m_acc += int'(pkt_bytes);
               m_left -= 1;
               if (int'(pkt_bytes) > int'(max_len) || m_acc > m_bud) begin
                  m_buf = 1; done = 1;
               end
               if (pkt_crc_bad) begin
                  m_txn = 1; done = 1;
               end
               if (pkt_pid != 2'd3 || m_left == 0) done = 1;
            end
            if (!done && frame_end && seen) begin
               m_txn = 1; done = 1;
            end
            if (done) begin
               m_ret = 1; m_active = 0;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         total++;
         if (retire !== m_ret || buf_err !== m_buf || txn_err !== m_txn) begin
            bad++;
            $display("FAIL %s model: got r=%b b=%b t=%b exp r=%b b=%b t=%b",
                     cur_req, retire, buf_err, txn_err, m_ret, m_buf, m_txn);
         end
      end
   end

   task automatic expect_out(input string req, input bit r, input bit b, input bit t);
      total++;
      if (retire !== r || buf_err !== b || txn_err !== t) begin
         bad++;
         $display("FAIL %s: got r=%b b=%b t=%b exp r=%b b=%b t=%b",
                  req, retire, buf_err, txn_err, r, b, t);
      end
   endtask

   task automatic load(input int ov, input int qh, input int bud);
      desc_load = 1'b1;
      dtd_mult = MW'(ov); qh_mult = MW'(qh); dtd_budget = BW'(bud);
      @(negedge clk);
      desc_load = 1'b0;
   endtask

   task automatic pkt(input int pid, input int nb, input bit crc, input bit fe);
      pkt_valid = 1'b1; pkt_pid = 2'(pid); pkt_bytes = LW'(nb);
      pkt_crc_bad = crc; frame_end = fe;
      @(negedge clk);
      pkt_valid = 1'b0; pkt_crc_bad = 1'b0; frame_end = 1'b0;
   endtask

   task automatic fend();
      frame_end = 1'b1;
      @(negedge clk);
      frame_end = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      expect_out("R12 reset", 0, 0, 0);
      rst_n = 1'b1;
      idle();
      expect_out("R12 after reset", 0, 0, 0);

      cur_req = "R2";
      load(0, 3, 1000);             // R1 queue-head multiplier 3
      pkt(3, 100, 0, 0); expect_out("R1 pkt1", 0, 0, 0);
      pkt(3, 100, 0, 0); expect_out("R1 pkt2", 0, 0, 0);
      pkt(3, 100, 0, 0); expect_out("R2 burst done", 1, 0, 0);
      idle();            expect_out("R9 one-cycle pulse", 0, 0, 0);

      cur_req = "R1";
      load(2, 3, 1000);
      pkt(3, 10, 0, 0);  expect_out("R1 ovr pkt1", 0, 0, 0);
      pkt(3, 10, 0, 0);  expect_out("R1 override 2", 1, 0, 0);

      cur_req = "R3";
      load(0, 3, 1000);
      pkt(0, 50, 0, 0);  expect_out("R3 DATA0 early", 1, 0, 0);

      cur_req = "R4";
      load(0, 3, 1000);
      pkt(3, 200, 0, 0); expect_out("R4 exactly max", 0, 0, 0);
      pkt(3, 201, 0, 0); expect_out("R4 over max", 1, 1, 0);
      idle();            expect_out("R9 flag held", 0, 1, 0);
      cur_req = "R10";
      pkt(3, 10, 1, 1);  expect_out("R10 ignored when idle", 0, 1, 0);
      cur_req = "R9";
      load(0, 2, 1000);  expect_out("R9 cleared by load", 0, 0, 0);

      cur_req = "R5";
      load(0, 3, 300);
      pkt(3, 150, 0, 0); expect_out("R5 half", 0, 0, 0);
      pkt(3, 150, 0, 0); expect_out("R5 exactly budget", 0, 0, 0);
      pkt(3, 1, 0, 0);   expect_out("R5 over budget", 1, 1, 0);

      cur_req = "R6";
      load(0, 3, 1000);
      pkt(3, 10, 1, 0);  expect_out("R6 crc", 1, 0, 1);

      cur_req = "R8";
      load(0, 3, 1000);
      fend();            expect_out("R8 empty frame", 0, 0, 0);
      cur_req = "R7";
      pkt(3, 10, 0, 0);  expect_out("R7 one packet", 0, 0, 0);
      fend();            expect_out("R7 partial burst", 1, 0, 1);
      load(0, 2, 1000);
      pkt(3, 10, 0, 1);  expect_out("R7 packet with frame end", 1, 0, 1);

      cur_req = "R11";
      load(0, 0, 1000);  expect_out("R11 zero multiplier", 1, 0, 0);
      idle();            expect_out("R11 single pulse", 0, 0, 0);

      cur_req = "R13";
      desc_load = 1'b1; dtd_mult = '0; qh_mult = MW'(2); dtd_budget = BW'(1000);
      pkt(0, 10, 0, 0);
      desc_load = 1'b0;
      expect_out("R13 load wins", 0, 0, 0);
      pkt(3, 10, 0, 0);  expect_out("R13 pkt1", 0, 0, 0);
      pkt(3, 10, 0, 0);  expect_out("R13 count intact", 1, 0, 0);

      cur_req = "R10";
      fend();            expect_out("R10 frame end idle", 0, 0, 0);
      idle();

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: got hung exp done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule